// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block supervises one power bridge. It watches a digitized supply voltage and a digitized junction temperature and turns them into three graded protection states. The first is an undervoltage lockout, which clears itself once the supply recovers. The second is a current-limit foldback select, which tells the current regulator to lower its threshold while the die runs hot. The third is an overtemperature shutdown request, which sits above the foldback region. Each state has its own hysteresis band, so a signal that hovers near a threshold does not make the output chatter.

The block also holds the bridge off for a power-on delay. Once the supply leaves lockout, it counts a number of timebase ticks before it raises a ready indication. The count starts over whenever lockout asserts again. The bridge control block consumes these outputs and handles fault latching and clearing. The analog sensing and the conversion to codes happen upstream of this block.

The supply code is unsigned and counts in steps of 50 mV. The temperature code is a signed two's-complement value in whole degrees Celsius. All thresholds and the delay length are parameters.

Top module: `supply_thermal_supervisor`

## Requirements
- R1: While reset is held, uv_lockout_o is 1, and foldback_o, overtemp_trip_o and power_ready_o are 0.
- R2: While lockout is released, a supply code below UV_ON_CODE (default 83, about 4.15 V) sets uv_lockout_o on the next clock edge.
- R3: Lockout is not latched. It clears on the next clock edge once the supply code is above UV_OFF_CODE (default 87, about 4.35 V). Codes from UV_ON_CODE to UV_OFF_CODE inclusive keep the present state.
- R4: foldback_o sets on the next edge when the signed temperature code is at least FOLD_ON (default 162). It clears only when the code falls below FOLD_ON minus HYST (default 12, so below 150).
- R5: overtemp_trip_o sets on the next edge when the signed temperature code is at least TRIP_ON (default 175). It clears only when the code falls below TRIP_ON minus HYST (below 163).
- R6: The temperature code is signed. A negative code such as -40 (9'h1D8) or -256 never sets foldback_o or overtemp_trip_o and clears both.
- R7: power_ready_o rises at the clock edge that samples the POD_TICKS-th tick_i pulse seen while uv_lockout_o is 0. Cycles with tick_i low do not count.
- R8: While uv_lockout_o is 1, the ready count restarts. power_ready_o is 0 from the edge after lockout is observed, and a fresh full count of POD_TICKS ticks is needed after the next release.
- R9: Whenever overtemp_trip_o is 1, foldback_o is also 1. This holds because the trip region lies inside the foldback region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Single-cycle timebase pulse for the power-on delay |
| supply_code_i | input | SUP_W (10) | Supply voltage code, unsigned, 50 mV per step |
| temp_code_i | input | TEMP_W (9) | Junction temperature code, signed, 1 °C per step |
| uv_lockout_o | output | 1 | Undervoltage lockout is active |
| foldback_o | output | 1 | Request for the reduced current-limit threshold |
| overtemp_trip_o | output | 1 | Request for overtemperature shutdown |
| power_ready_o | output | 1 | Power-on delay has elapsed and the supply is valid |

## Verification
Each comparator output is a single register. Its result therefore appears one clock edge after the input code is applied, and power_ready_o moves at the same edge as the tick that completes the count.

The bench drives each stimulus at a falling edge and pushes the expected values for the following rising edge into a queue. A monitor pops that entry a short time after the rising edge and compares all four outputs. Because every step has exactly one expected item due at one fixed edge, no check can drift into the wrong cycle. The stimulus walks every threshold, both sides of each hysteresis band, and gaps in the tick stream.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Widths of the two sensor codes
  localparam int SUP_W_DEF  = 10;
  localparam int TEMP_W_DEF = 9;

  // Comparator polarity: the state sets above the set level, or below it
  typedef enum logic {
    CMP_BELOW = 1'b0,
    CMP_ABOVE = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/supv_rst_sync.sv
module supv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/supv_hyst_cmp.sv
module supv_hyst_cmp
  import supv_pkg::*;
#(
  parameter int       W       = 10,
  parameter int       SET_LVL = 0,
  parameter int       CLR_LVL = 0,
  parameter cmp_dir_e DIR     = CMP_ABOVE,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] value_i,
  output logic                state_o
);
  logic set_hit;
  logic clr_hit;
  logic state_d;
  logic state_q;

  generate
    if (DIR == CMP_ABOVE) begin : g_above
      always_comb begin
        set_hit = (value_i >= SET_LVL);
        clr_hit = (value_i <  CLR_LVL);
      end
    end else begin : g_below
      always_comb begin
        set_hit = (value_i <  SET_LVL);
        clr_hit = (value_i >  CLR_LVL);
      end
    end
  endgenerate

  always_comb begin
    if (state_q) state_d = !clr_hit;
    else         state_d = set_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_VAL;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/supv_ready_timer.sv
module supv_ready_timer #(
  parameter int POD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  output logic ready_o
);
  localparam int CW = (POD_TICKS < 2) ? 1 : $clog2(POD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(POD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          rdy_q;
  logic          rdy_d;
  logic          cnt_en;

  // The counter advances only on a tick while the supply is valid and not yet ready
  assign cnt_en = tick_i && !hold_i && !rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (hold_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/supply_thermal_supervisor.sv
module supply_thermal_supervisor
  import supv_pkg::*;
#(
  parameter int SUP_W       = SUP_W_DEF,
  parameter int TEMP_W      = TEMP_W_DEF,
  parameter int UV_ON_CODE  = 83,
  parameter int UV_OFF_CODE = 87,
  parameter int FOLD_ON     = 162,
  parameter int TRIP_ON     = 175,
  parameter int HYST        = 12,
  parameter int POD_TICKS   = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic [SUP_W-1:0]         supply_code_i,
  input  logic signed [TEMP_W-1:0] temp_code_i,
  output logic                     uv_lockout_o,
  output logic                     foldback_o,
  output logic                     overtemp_trip_o,
  output logic                     power_ready_o
);
  localparam int SUP_XW   = SUP_W + 1;
  localparam int FOLD_OFF = FOLD_ON - HYST;
  localparam int TRIP_OFF = TRIP_ON - HYST;

  logic                     rst_n_sync;
  logic signed [SUP_XW-1:0] sup_ext;

  assign sup_ext = $signed({1'b0, supply_code_i});

  supv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  supv_hyst_cmp #(
    .W(SUP_XW), .SET_LVL(UV_ON_CODE), .CLR_LVL(UV_OFF_CODE),
    .DIR(CMP_BELOW), .RST_VAL(1'b1)
  ) u_uv (
    .clk(clk), .rst_n(rst_n_sync), .value_i(sup_ext), .state_o(uv_lockout_o)
  );

  supv_hyst_cmp #(
    .W(TEMP_W), .SET_LVL(FOLD_ON), .CLR_LVL(FOLD_OFF),
    .DIR(CMP_ABOVE), .RST_VAL(1'b0)
  ) u_fold (
    .clk(clk), .rst_n(rst_n_sync), .value_i(temp_code_i), .state_o(foldback_o)
  );

  supv_hyst_cmp #(
    .W(TEMP_W), .SET_LVL(TRIP_ON), .CLR_LVL(TRIP_OFF),
    .DIR(CMP_ABOVE), .RST_VAL(1'b0)
  ) u_trip (
    .clk(clk), .rst_n(rst_n_sync), .value_i(temp_code_i), .state_o(overtemp_trip_o)
  );

  supv_ready_timer #(.POD_TICKS(POD_TICKS)) u_pod (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick_i  (tick_i),
    .hold_i  (uv_lockout_o),
    .ready_o (power_ready_o)
  );
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int SUP_W       = 10,
  parameter int TEMP_W      = 9,
  parameter int UV_ON_CODE  = 83,
  parameter int UV_OFF_CODE = 87,
  parameter int FOLD_ON     = 162,
  parameter int TRIP_ON     = 175,
  parameter int HYST        = 12
) (
  input logic                     clk,
  input logic                     rst_n_sync,
  input logic                     tick_i,
  input logic [SUP_W-1:0]         supply_code_i,
  input logic signed [TEMP_W-1:0] temp_code_i,
  input logic                     uv_lockout_o,
  input logic                     foldback_o,
  input logic                     overtemp_trip_o,
  input logic                     power_ready_o
);
  // R2
  uv_set_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!uv_lockout_o && (int'(supply_code_i) < UV_ON_CODE)) |=> uv_lockout_o);

  // R3
  uv_release_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(uv_lockout_o) |-> (int'($past(supply_code_i)) > UV_OFF_CODE));

  // R4
  fold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(foldback_o) |-> ($past(temp_code_i) >= FOLD_ON));

  // R4
  fold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(foldback_o) |-> ($past(temp_code_i) < (FOLD_ON - HYST)));

  // R5
  trip_set_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (temp_code_i >= TRIP_ON) |=> overtemp_trip_o);

  // R5
  trip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(overtemp_trip_o) |-> ($past(temp_code_i) < (TRIP_ON - HYST)));

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(power_ready_o) |-> ($past(tick_i) && !$past(uv_lockout_o)));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    uv_lockout_o |=> !power_ready_o);

  // R9
  trip_in_fold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    overtemp_trip_o |-> foldback_o);
endmodule

bind supply_thermal_supervisor supv_checker #(
  .SUP_W(SUP_W), .TEMP_W(TEMP_W), .UV_ON_CODE(UV_ON_CODE),
  .UV_OFF_CODE(UV_OFF_CODE), .FOLD_ON(FOLD_ON), .TRIP_ON(TRIP_ON), .HYST(HYST)
) chk_i (
  .clk(clk), .rst_n_sync(rst_n_sync), .tick_i(tick_i),
  .supply_code_i(supply_code_i), .temp_code_i(temp_code_i),
  .uv_lockout_o(uv_lockout_o), .foldback_o(foldback_o),
  .overtemp_trip_o(overtemp_trip_o), .power_ready_o(power_ready_o)
);

// File: tb/supply_thermal_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_thermal_supervisor_tb_top;
  localparam int UV_ON  = 83;
  localparam int UV_OFF = 87;
  localparam int F_ON   = 162;
  localparam int T_ON   = 175;
  localparam int HY     = 12;
  localparam int POD    = 6;

  typedef struct {
    logic  uv;
    logic  fb;
    logic  ot;
    logic  rdy;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [9:0]        sup = 10'd0;
  logic signed [8:0] temp = 9'sd25;
  logic uv_o, fb_o, ot_o, rdy_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // Requirement-level expectations held by the bench
  logic m_uv = 1'b1, m_fb = 1'b0, m_ot = 1'b0, m_rdy = 1'b0;
  int   m_cnt = 0;

  always #10 clk = ~clk;

  supply_thermal_supervisor #(
    .UV_ON_CODE(UV_ON), .UV_OFF_CODE(UV_OFF), .FOLD_ON(F_ON),
    .TRIP_ON(T_ON), .HYST(HY), .POD_TICKS(POD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_code_i(sup),
    .temp_code_i(temp), .uv_lockout_o(uv_o), .foldback_o(fb_o),
    .overtemp_trip_o(ot_o), .power_ready_o(rdy_o)
  );

  task automatic chk(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b", tag, name, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, push the outputs due after the next rising edge
  task automatic step(input int s, input int t, input logic tk, input string tag);
    logic n_uv, n_fb, n_ot, n_rdy;
    int   n_cnt;
    exp_t e;
    @(negedge clk);
    sup = 10'(s); temp = 9'(t); tick = tk;
    n_uv = m_uv ? !(s > UV_OFF) : (s < UV_ON);
    n_fb = m_fb ? !(t < F_ON - HY) : (t >= F_ON);
    n_ot = m_ot ? !(t < T_ON - HY) : (t >= T_ON);
    n_rdy = m_rdy; n_cnt = m_cnt;
    if (m_uv) begin
      n_rdy = 1'b0; n_cnt = 0;
    end else if (tk && !m_rdy) begin
      if (m_cnt == POD - 1) n_rdy = 1'b1;
      else                  n_cnt = m_cnt + 1;
    end
    m_uv = n_uv; m_fb = n_fb; m_ot = n_ot; m_rdy = n_rdy; m_cnt = n_cnt;
    e.uv = n_uv; e.fb = n_fb; e.ot = n_ot; e.rdy = n_rdy; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compare just after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "uv_lockout", uv_o, e.uv);
      chk(e.tag, "foldback", fb_o, e.fb);
      chk(e.tag, "overtemp_trip", ot_o, e.ot);
      chk(e.tag, "power_ready", rdy_o, e.rdy);
    end
  end

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "uv_lockout", uv_o, 1'b1);
    chk("R1", "foldback", fb_o, 1'b0);
    chk("R1", "overtemp_trip", ot_o, 1'b0);
    chk("R1", "power_ready", rdy_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);   // synchronizer settles with inputs idle (supply 0)

    // R3 band codes keep lockout, R3 release above the band
    step(83, 25, 1'b1, "R3");
    step(87, 25, 1'b1, "R3");
    step(88, 25, 1'b0, "R3");
    // R7 ready counts only tick cycles
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b0, "R7");
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b0, "R7");
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b1, "R7");
    step(100, 25, 1'b1, "R7");
    // R3 in-band code does not set lockout once released
    step(85, 25, 1'b1, "R3");
    step(83, 25, 1'b1, "R3");
    // R2 drop below set level; R8 ready clears and count restarts
    step(82, 25, 1'b1, "R2");
    step(82, 25, 1'b1, "R8");
    step(86, 25, 1'b1, "R8");
    step(90, 25, 1'b1, "R8");
    for (int i = 0; i < POD + 1; i++) step(90, 25, 1'b1, "R8");
    // R2 deep drop to zero
    step(0, 25, 1'b0, "R2");
    step(200, 25, 1'b0, "R3");
    // R4 foldback thresholds
    step(200, 161, 1'b0, "R4");
    step(200, 162, 1'b0, "R4");
    step(200, 150, 1'b0, "R4");
    step(200, 149, 1'b0, "R4");
    step(200, 163, 1'b0, "R4");
    // R5 trip thresholds, R9 trip implies foldback
    step(200, 174, 1'b0, "R5");
    step(200, 175, 1'b0, "R5");
    step(200, 163, 1'b0, "R9");
    step(200, 162, 1'b0, "R5");
    step(200, 255, 1'b0, "R5");
    // R6 negative codes clear both
    step(200, -40, 1'b0, "R6");
    step(200, -256, 1'b0, "R6");
    step(200, 190, 1'b0, "R9");
    step(200, -1, 1'b0, "R6");
    step(200, 25, 1'b0, "R6");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule